// File: doc/BRIEF.md
# PMBus Target Interface with Packet Error Checking and Fault Alert

This block is the target (slave) side of an SMBus/PMBus management link inside a power module. It samples the open-drain clock and data lines through synchronizers in the system clock domain, detects START, repeated START and STOP conditions, and shifts bytes in and out. It pulls the data line low through an output-enable pin. The target's 7-bit address comes from two strapped octal digits. A code that is out of range or reserved falls back to address 127.

The host can write a byte or a word, read a byte or a word, or send a command byte with no data. These go to a small set of registers: an operation byte, an output-voltage word, a status byte and a status word. Each transaction may carry a CRC-8 packet error check byte. The host chooses whether to send one on a write. Every read response ends with one. A write takes effect only at the STOP that closes it.

A fault input latches into the status register and pulls the active-low alert output. The alert stays low until the host sends the clear-faults command. While the alert is active, the host keeps talking to the target at its normal address. A store-defaults command produces a one-cycle strobe toward nonvolatile storage, and the strobe's sink reads the register outputs.

Top module: `pmbus_target`

## Requirements
- R1: The resolved address is 8 × high digit + low digit, with each digit a 3-bit strap value, when both flags are clear and the result is not reserved.
- R2: If either strap flag marks its digit as out of range, the resolved address is 127.
- R3: A resolved value of 0 to 12, 40, 44, 45 or 55 is replaced by 127.
- R4: An address byte is acknowledged only when its upper seven bits equal the resolved address. On any other address the target releases the data line and no register changes. The target changes the data line only while the clock is low.
- R5: The supported commands and their data lengths are: 0x01 operation (1 byte), 0x21 output voltage (2 bytes, low byte first), 0x78 status byte (1), 0x79 status word (2), 0x03 clear-faults (0) and 0x11 store-defaults (0). A write with exactly this many data bytes takes effect at STOP and not before. The operation byte resets to 0x80 and the voltage word resets to 0x0000.
- R6: A write followed by one extra byte takes effect only when the CRC-8 (polynomial 0x07, initial value 0) over the address byte, command, data and that extra byte is zero. Any other write is discarded and sets the communication-fault bit.
- R7: A read returns the data bytes low byte first and then a PEC byte. The PEC is the CRC-8 over the write address, command, read address and data bytes.
- R8: An unsupported command code is not acknowledged and sets the communication-fault bit.
- R9: The status byte holds the fault in bit 0 and the communication fault in bit 1. The status word carries the status byte in its low byte and zero in its high byte. A high fault input sets bit 0 on the next cycle, and the bit stays set after the input drops. The alert output is low while any status bit is set.
- R10: Clear-faults clears both status bits and releases the alert. A fault input that is still high re-latches at once. While the alert is active, the target still answers at its resolved address.
- R11: Store-defaults raises the store strobe for exactly one cycle and leaves the operation and voltage registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND) |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_hi | input | 3 | High octal address digit |
| strap_hi_bad | input | 1 | High digit sensed out of range |
| strap_lo | input | 3 | Low octal address digit |
| strap_lo_bad | input | 1 | Low digit sensed out of range |
| fault_i | input | 1 | Fault condition from the power stage |
| alert_n | output | 1 | Active-low alert; the pad drives low only |
| own_addr | output | 7 | Resolved target address |
| op_q | output | 8 | Operation register |
| vout_q | output | 16 | Output-voltage register |
| store_pulse | output | 1 | One-cycle commit strobe to nonvolatile storage |

## Verification
A bit counter or shift register that is out of step shows at the ports within one byte time. The data line is then driven in the wrong clock slot, so the host sees a lost acknowledge or a garbled read byte, and the PEC byte at the end of the same read also mismatches. A CRC register that runs on a wrong byte stream has a different failure. Writes with correct PEC are rejected and the alert falls right after STOP. Reads carry a wrong final byte. A stuck status latch shows on the alert pin one cycle after the fault input or the clear command. The full address sweep exposes any slip in address resolution without a bus transaction.

// File: rtl/pmb_pkg.sv
// Shared command codes, link states and CRC-8 helper for the PMBus target.
// Assumes byte-wide CRC stepping is cheap enough to evaluate combinationally.
package pmb_pkg;
    localparam logic [7:0] CMD_OPER   = 8'h01;
    localparam logic [7:0] CMD_CLR    = 8'h03;
    localparam logic [7:0] CMD_STORE  = 8'h11;
    localparam logic [7:0] CMD_VOUT   = 8'h21;
    localparam logic [7:0] CMD_STAT_B = 8'h78;
    localparam logic [7:0] CMD_STAT_W = 8'h79;
    localparam logic [6:0] ADDR_FALLBACK = 7'd127;
    localparam logic [7:0] PEC_POLY = 8'h07;

    typedef enum logic [2:0] {
        LK_IDLE, LK_RX, LK_ACKW, LK_ACK, LK_TX, LK_TXA, LK_TXN
    } link_st_t;

    // One CRC-8 update over a full byte, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ PEC_POLY) : (r << 1);
        end
        return r;
    endfunction

    // Data length of a command; 0 for command-only codes and unknown codes.
    function automatic logic [2:0] cmd_len(input logic [7:0] c);
        case (c)
            CMD_OPER, CMD_STAT_B: return 3'd1;
            CMD_VOUT, CMD_STAT_W: return 3'd2;
            default:              return 3'd0;
        endcase
    endfunction

    function automatic logic cmd_known(input logic [7:0] c);
        return (c == CMD_OPER) || (c == CMD_CLR) || (c == CMD_STORE) ||
               (c == CMD_VOUT) || (c == CMD_STAT_B) || (c == CMD_STAT_W);
    endfunction
endpackage

// File: rtl/pmb_sync.sv
// Input synchronizer for an idle-high bus line.
// Assumes STAGES >= 1; resets to the idle (high) level.
module pmb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single flop stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift chain of STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pmb_addr.sv
// Resolves the 7-bit target address from two strapped octal digits.
// Out-of-range digits and reserved codes fall back to address 127.
module pmb_addr
    import pmb_pkg::*;
(
    input  logic [2:0] hi,
    input  logic [2:0] lo,
    input  logic       hi_bad,
    input  logic       lo_bad,
    output logic [6:0] addr
);
    logic [6:0] raw;
    logic       reserved;

    // Combine digits and screen the reserved set.
    always_comb begin
        raw      = {1'b0, hi, lo};
        reserved = (raw <= 7'd12) || (raw == 7'd40) || (raw == 7'd44) ||
                   (raw == 7'd45) || (raw == 7'd55);
        addr     = (hi_bad || lo_bad || reserved) ? ADDR_FALLBACK : raw;
    end
endmodule

// File: rtl/pmb_link.sv
// Bit-level SMBus target engine: START/STOP detection, byte receive with
// acknowledge, byte transmit with host acknowledge. Inputs are already
// synchronized. Data line changes are made only after a clock fall.
module pmb_link
    import pmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       ack_en,
    input  logic       tx_go,
    input  logic [7:0] tx_byte,
    output logic       start_evt,
    output logic       stop_evt,
    output logic       rx_done,
    output logic [7:0] rx_byte,
    output logic       tx_load,
    output logic       sda_oe
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(7);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(8);

    link_st_t         st;
    logic             scl_q, sda_q, ack_q;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       shreg;
    logic             scl_rise, scl_fall;

    // Line edge and bus condition decode.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
        rx_done   = (st == LK_RX) && scl_rise && (cnt == LAST_BIT);
        rx_byte   = {shreg[6:0], sda_s};
        tx_load   = scl_fall && (((st == LK_ACK) && tx_go) || (st == LK_TXN));
    end

    // Previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Bit sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= LK_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            ack_q  <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_evt) begin
            st     <= LK_RX;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_evt) begin
            st     <= LK_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                LK_RX: if (scl_rise) begin
                    shreg <= rx_byte;
                    if (cnt == LAST_BIT) begin
                        st    <= LK_ACKW;
                        ack_q <= ack_en;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LK_ACKW: if (scl_fall) begin
                    if (ack_q) begin
                        sda_oe <= 1'b1;
                        st     <= LK_ACK;
                    end else begin
                        st <= LK_IDLE;
                    end
                end
                LK_ACK: if (scl_fall) begin
                    cnt <= '0;
                    if (tx_go) begin
                        shreg  <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        st     <= LK_TX;
                    end else begin
                        sda_oe <= 1'b0;
                        st     <= LK_RX;
                    end
                end
                LK_TX: begin
                    if (scl_rise) cnt <= cnt + 1'b1;
                    if (scl_fall) begin
                        if (cnt == ALL_BITS) begin
                            sda_oe <= 1'b0;
                            st     <= LK_TXA;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= shreg << 1;
                        end
                    end
                end
                LK_TXA: if (scl_rise) st <= sda_s ? LK_IDLE : LK_TXN;
                LK_TXN: if (scl_fall) begin
                    shreg  <= tx_byte;
                    sda_oe <= ~tx_byte[7];
                    cnt    <= '0;
                    st     <= LK_TX;
                end
                default: st <= LK_IDLE;
            endcase
        end
    end

    // The data line may only start being pulled while the clock is low.
    assert_oe_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/pmbus_target.sv
// PMBus target top: synchronizers, address resolution, bit engine and the
// transaction/command layer with PEC, status latches, alert and store strobe.
// Assumes the host does not stretch the clock and uses no block transfers.
module pmbus_target
    import pmb_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  OP_RESET    = 8'h80,
    parameter logic [15:0] VOUT_RESET  = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [2:0]  strap_hi,
    input  logic        strap_hi_bad,
    input  logic [2:0]  strap_lo,
    input  logic        strap_lo_bad,
    input  logic        fault_i,
    output logic        alert_n,
    output logic [6:0]  own_addr,
    output logic [7:0]  op_q,
    output logic [15:0] vout_q,
    output logic        store_pulse
);
    localparam int IDX_W = 2;
    localparam int NB_W  = 3;

    logic scl_s, sda_s;
    logic start_evt, stop_evt, rx_done, tx_load, ack_en;
    logic [7:0] rx_byte, tx_byte;

    logic             in_txn, sel, rd_phase, have_cmd;
    logic [IDX_W-1:0] idx;
    logic [NB_W-1:0]  nbytes;
    logic [1:0]       tcnt;
    logic [7:0]       cmd, d0, d1, crc;
    logic             flt, cml;
    logic [15:0]      rd_val;
    logic [7:0]       status;
    logic [NB_W-1:0]  len;
    logic             wr_end, len_ok, wr_ok, wr_bad, clear_cmd, cml_set;

    pmb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
    pmb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    pmb_addr u_addr (
        .hi(strap_hi), .lo(strap_lo), .hi_bad(strap_hi_bad), .lo_bad(strap_lo_bad),
        .addr(own_addr)
    );

    pmb_link u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .ack_en(ack_en), .tx_go(rd_phase), .tx_byte(tx_byte),
        .start_evt(start_evt), .stop_evt(stop_evt), .rx_done(rx_done),
        .rx_byte(rx_byte), .tx_load(tx_load), .sda_oe(sda_oe)
    );

    // Acknowledge decision for the byte just received.
    always_comb begin
        if (idx == '0)
            ack_en = (rx_byte[7:1] == own_addr) && (!rx_byte[0] || have_cmd);
        else if (idx == IDX_W'(1))
            ack_en = sel && cmd_known(rx_byte);
        else
            ack_en = sel;
    end

    // Read-back value and next byte to transmit (data, then PEC).
    always_comb begin
        status = {6'b0, cml, flt};
        case (cmd)
            CMD_OPER:               rd_val = {8'h00, op_q};
            CMD_VOUT:               rd_val = vout_q;
            CMD_STAT_B, CMD_STAT_W: rd_val = {8'h00, status};
            default:                rd_val = 16'h0000;
        endcase
        len = cmd_len(cmd);
        if ({1'b0, tcnt} < len) tx_byte = tcnt[0] ? rd_val[15:8] : rd_val[7:0];
        else                    tx_byte = crc;
    end

    // Write acceptance at STOP: exact length, or length plus a valid PEC.
    always_comb begin
        wr_end    = stop_evt && in_txn && sel && have_cmd && !rd_phase;
        len_ok    = (nbytes == len) || ((nbytes == len + 1'b1) && (crc == 8'h00));
        wr_ok     = wr_end && len_ok;
        wr_bad    = wr_end && !len_ok;
        clear_cmd = wr_ok && (cmd == CMD_CLR);
        cml_set   = (rx_done && (idx == IDX_W'(1)) && sel && !ack_en) || wr_bad;
    end

    // Transaction tracking, data capture and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_txn <= 1'b0; sel <= 1'b0; rd_phase <= 1'b0; have_cmd <= 1'b0;
            idx <= '0; nbytes <= '0; tcnt <= '0;
            cmd <= '0; d0 <= '0; d1 <= '0; crc <= '0;
        end else if (start_evt) begin
            idx    <= '0;
            tcnt   <= '0;
            in_txn <= 1'b1;
            if (!in_txn) begin
                crc <= '0; nbytes <= '0; have_cmd <= 1'b0; rd_phase <= 1'b0; sel <= 1'b0;
            end
        end else if (stop_evt) begin
            in_txn <= 1'b0;
            sel    <= 1'b0;
        end else if (rx_done) begin
            if (idx != '1) idx <= idx + 1'b1;
            if (idx == '0) begin
                sel <= ack_en;
                if (ack_en) begin
                    crc      <= crc8_step(crc, rx_byte);
                    rd_phase <= rx_byte[0];
                end
            end else if (idx == IDX_W'(1)) begin
                if (ack_en) begin
                    cmd      <= rx_byte;
                    have_cmd <= 1'b1;
                    crc      <= crc8_step(crc, rx_byte);
                end
            end else begin
                if (nbytes == '0) d0 <= rx_byte;
                if (nbytes == NB_W'(1)) d1 <= rx_byte;
                if (nbytes != '1) nbytes <= nbytes + 1'b1;
                crc <= crc8_step(crc, rx_byte);
            end
        end else if (tx_load) begin
            crc <= crc8_step(crc, tx_byte);
            if (tcnt != '1) tcnt <= tcnt + 1'b1;
        end
    end

    // Volatile configuration registers and store strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= OP_RESET;
            vout_q      <= VOUT_RESET;
            store_pulse <= 1'b0;
        end else begin
            store_pulse <= wr_ok && (cmd == CMD_STORE);
            if (wr_ok && (cmd == CMD_OPER)) op_q   <= d0;
            if (wr_ok && (cmd == CMD_VOUT)) vout_q <= {d1, d0};
        end
    end

    // Status latches: set by fault input or bus errors, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt <= 1'b0;
            cml <= 1'b0;
        end else begin
            flt <= clear_cmd ? fault_i : (flt | fault_i);
            cml <= clear_cmd ? 1'b0 : (cml | cml_set);
        end
    end

    assign alert_n = ~(flt | cml);

    assert_bad_strap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_hi_bad || strap_lo_bad) |-> (own_addr == ADDR_FALLBACK));

    assert_no_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_addr > 7'd12) && (own_addr != 7'd40) && (own_addr != 7'd44) &&
        (own_addr != 7'd45) && (own_addr != 7'd55));

    assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(op_q) || !$stable(vout_q)) |-> $past(stop_evt));

    assert_fault_alert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !alert_n);

    assert_release_by_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_n) |-> $past(clear_cmd));

    assert_store_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        store_pulse |=> !store_pulse);
endmodule

// File: tb/pmbus_target_bench.sv
// Self-checking bench: full strap sweep plus bus transactions driven by a
// host model on a wired-AND data line.
module pmbus_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 8;
    localparam int WD_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1, host_sda = 1'b1;
    logic sda_bus;
    logic sda_oe, alert_n, store_pulse;
    logic [2:0] strap_hi = 3'd3, strap_lo = 3'd4;
    logic strap_hi_bad = 1'b0, strap_lo_bad = 1'b0, fault_i = 1'b0;
    logic [6:0] own_addr;
    logic [7:0] op_q;
    logic [15:0] vout_q;

    int n_chk = 0, n_fail = 0, pulses = 0, cyc = 0;
    logic done = 1'b0;

    assign sda_bus = host_sda & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    pmbus_target u_pmbus_target (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_hi(strap_hi), .strap_hi_bad(strap_hi_bad), .strap_lo(strap_lo),
        .strap_lo_bad(strap_lo_bad), .fault_i(fault_i), .alert_n(alert_n),
        .own_addr(own_addr), .op_q(op_q), .vout_q(vout_q), .store_pulse(store_pulse)
    );

    always @(posedge clk) if (store_pulse) pulses <= pulses + 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_CYCLES && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_CYCLES);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic wq; repeat (QTR) @(negedge clk); endtask
    task automatic bus_start; host_sda = 1; host_scl = 1; wq; host_sda = 0; wq; host_scl = 0; wq; endtask
    task automatic bus_rstart; host_sda = 1; wq; host_scl = 1; wq; host_sda = 0; wq; host_scl = 0; wq; endtask
    task automatic bus_stop; host_sda = 0; wq; host_scl = 1; wq; host_sda = 1; wq; wq; endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wq; host_scl = 1; wq; wq; host_scl = 0; wq;
        end
        host_sda = 1; wq; host_scl = 1; wq; ack = !sda_bus; wq; host_scl = 0; wq;
    endtask

    task automatic get_byte(input logic last, output logic [7:0] b);
        host_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            wq; host_scl = 1; wq; b[i] = sda_bus; wq; host_scl = 0; wq;
        end
        host_sda = last; wq; host_scl = 1; wq; wq; host_scl = 0; wq; host_sda = 1;
    endtask

    // pec_mode: 0 none, 1 correct, 2 corrupted
    task automatic write_txn(input logic [6:0] a, input logic [7:0] c, input int nb,
                             input logic [15:0] data, input int pec_mode,
                             output logic a_ack, output logic c_ack);
        logic [7:0] crc, b;
        logic ack;
        crc = 8'h00;
        bus_start;
        b = {a, 1'b0}; put_byte(b, a_ack); crc = bcrc(crc, b);
        put_byte(c, c_ack); crc = bcrc(crc, c);
        for (int k = 0; k < nb; k++) begin
            b = data[8*k +: 8]; put_byte(b, ack); crc = bcrc(crc, b);
        end
        if (pec_mode == 1) put_byte(crc, ack);
        if (pec_mode == 2) put_byte(crc ^ 8'h5A, ack);
        bus_stop;
    endtask

    task automatic read_txn(input logic [6:0] a, input logic [7:0] c, input int nb,
                            output logic [15:0] val, output logic pec_ok, output logic a_ack);
        logic [7:0] crc, b;
        logic ack;
        crc = 8'h00; val = 16'h0000;
        bus_start;
        b = {a, 1'b0}; put_byte(b, a_ack); crc = bcrc(crc, b);
        put_byte(c, ack); crc = bcrc(crc, c);
        bus_rstart;
        b = {a, 1'b1}; put_byte(b, ack); crc = bcrc(crc, b);
        for (int k = 0; k < nb; k++) begin
            get_byte(1'b0, b); val[8*k +: 8] = b; crc = bcrc(crc, b);
        end
        get_byte(1'b1, b);
        pec_ok = (b == crc);
        bus_stop;
    endtask

    initial begin
        logic aa, ca, pk;
        logic [15:0] v;
        int p0;
        logic [6:0] me;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "alert after reset", alert_n, 1);
        chk("R5", "op reset", op_q, 8'h80);
        chk("R5", "vout reset", vout_q, 16'h0000);
        chk("R4", "line released after reset", sda_oe, 0);
        chk("R11", "strobe idle after reset", store_pulse, 0);

        // Strap sweep: every digit pair with every flag combination.
        for (int h = 0; h < 8; h++) begin
            for (int l = 0; l < 8; l++) begin
                for (int f = 0; f < 4; f++) begin
                    int raw, ex;
                    logic rsv;
                    strap_hi = 3'(h); strap_lo = 3'(l);
                    strap_hi_bad = f[0]; strap_lo_bad = f[1];
                    @(negedge clk);
                    raw = 8 * h + l;
                    rsv = (raw <= 12) || raw == 40 || raw == 44 || raw == 45 || raw == 55;
                    ex = (f != 0 || rsv) ? 127 : raw;
                    if (f != 0)  chk("R2", "flagged strap", own_addr, ex);
                    else if (rsv) chk("R3", "reserved code", own_addr, ex);
                    else          chk("R1", "digit address", own_addr, ex);
                end
            end
        end
        strap_hi = 3'd3; strap_lo = 3'd4; strap_hi_bad = 0; strap_lo_bad = 0;
        @(negedge clk);
        me = 7'd28;

        write_txn(7'd29, 8'h01, 1, 16'h0011, 0, aa, ca);
        chk("R4", "foreign address nack", aa, 0);
        chk("R4", "foreign write no effect", op_q, 8'h80);

        write_txn(me, 8'h01, 1, 16'h005A, 0, aa, ca);
        chk("R4", "own address ack", aa, 1);
        chk("R5", "byte write no pec", op_q, 8'h5A);

        write_txn(me, 8'h01, 1, 16'h003C, 1, aa, ca);
        chk("R6", "byte write good pec", op_q, 8'h3C);
        write_txn(me, 8'h21, 2, 16'h1234, 1, aa, ca);
        chk("R6", "word write good pec", vout_q, 16'h1234);

        write_txn(me, 8'h21, 2, 16'hBEEF, 2, aa, ca);
        chk("R6", "bad pec discarded", vout_q, 16'h1234);
        chk("R6", "bad pec raises alert", alert_n, 0);
        read_txn(me, 8'h78, 1, v, pk, aa);
        chk("R10", "answers while alert", aa, 1);
        chk("R9", "status comm bit", v, 16'h0002);
        chk("R7", "status read pec", pk, 1);

        write_txn(me, 8'h03, 0, 16'h0, 0, aa, ca);
        chk("R10", "clear releases alert", alert_n, 1);
        read_txn(me, 8'h78, 1, v, pk, aa);
        chk("R10", "status after clear", v, 16'h0000);

        read_txn(me, 8'h21, 2, v, pk, aa);
        chk("R7", "word read", v, 16'h1234);
        chk("R7", "word read pec", pk, 1);
        read_txn(me, 8'h01, 1, v, pk, aa);
        chk("R7", "byte read", v, 16'h003C);
        chk("R7", "byte read pec", pk, 1);

        write_txn(me, 8'h55, 1, 16'h0077, 0, aa, ca);
        chk("R8", "unknown command nack", ca, 0);
        chk("R8", "unknown command alert", alert_n, 0);
        read_txn(me, 8'h79, 2, v, pk, aa);
        chk("R8", "status word comm bit", v, 16'h0002);
        chk("R7", "status word pec", pk, 1);
        write_txn(me, 8'h03, 0, 16'h0, 1, aa, ca);
        chk("R10", "clear with pec", alert_n, 1);

        fault_i = 1; repeat (3) @(negedge clk); fault_i = 0;
        repeat (2) @(negedge clk);
        chk("R9", "fault latched alert", alert_n, 0);
        read_txn(me, 8'h78, 1, v, pk, aa);
        chk("R9", "fault status bit", v, 16'h0001);
        fault_i = 1;
        write_txn(me, 8'h03, 0, 16'h0, 0, aa, ca);
        chk("R10", "persistent fault relatches", alert_n, 0);
        fault_i = 0;
        write_txn(me, 8'h03, 0, 16'h0, 0, aa, ca);
        chk("R10", "clear after fault gone", alert_n, 1);

        p0 = pulses;
        write_txn(me, 8'h11, 0, 16'h0, 0, aa, ca);
        repeat (4) @(negedge clk);
        chk("R11", "single store strobe", pulses - p0, 1);
        chk("R11", "store keeps op", op_q, 8'h3C);
        chk("R11", "store keeps vout", vout_q, 16'h1234);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule